// File: doc/BRIEF.md
# SD Command-Line Response Receiver

This block collects the 48-bit reply that a card returns on the single-bit command line after the host has issued a command. The host controller pulses `start_rx` in the cycle in which its own end bit is on the line. The block then waits through the bus turnaround, skips any high bits the card drives before replying, and takes the first low bit as the start of the reply. It shifts in the remaining 47 bits and checks the framing bits, the command index echo and the CRC7. It splits the argument of a published-address reply into the new relative card address and the 16 status bits. The pad is modelled as a sampled input bit plus the host's output-enable flag. While that flag is high, the host is driving the line and the line is not examined while the block waits for the card.

The controller is a single state machine with five states. S_IDLE holds after reset until the first `start_rx`. S_TURN spends two cycles on the turnaround. S_HUNT waits up to 64 cycles for the start bit. S_SHIFT takes in the remaining 47 bits. S_DONE holds the result until the next `start_rx`. The transitions are as follows:
- start_rx: from any state to S_TURN.
- turn_ok: S_TURN to S_HUNT, after the last turnaround cycle.
- turn_early: S_TURN to S_DONE, when a low bit appears during the turnaround.
- hunt_found: S_HUNT to S_SHIFT, on the first low bit.
- hunt_expire: S_HUNT to S_DONE, when the hunt window runs out.
- shift_last: S_SHIFT to S_DONE, after bit 0 is sampled.

The field positions below are given with bit 47 as the first bit on the line. Edges are counted from the rising edge at which `start_rx` is sampled, which is edge 0.

Top module: `sd_resp_rx`

## Requirements
- R1: After reset, `done`, `crc_err`, `frame_err`, `index_err`, `timeout` and `early_err` are all 0.
- R2: The turnaround covers edges 1 and 2. A sampled low bit at either edge, with `host_oe` low, ends reception at once with `done`=1 and `early_err`=1, and the other four flags at 0.
- R3: High bits in the hunt window are ignored. The hunt window is edges 3 to 66, which allows 0 to 63 idle bits. The first low bit sampled in this window is bit 47, the start bit. The 47 edges that follow supply bits 46 down to 0.
- R4: During the turnaround and the hunt window, any cycle in which `host_oe` is 1 is not examined. A low line in such a cycle neither starts a frame nor raises `early_err`.
- R5: If no start bit has arrived by edge 66, `done`=1 and `timeout`=1 after edge 66, with the other flags at 0. After edge 65, `done` is still 0.
- R6: `frame_err`=1 when bit 46 (the transmission bit, which must be 0) is 1, or when bit 0 (the end bit, which must be 1) is 0.
- R7: `index_err`=1 when bits 45:40 differ from the `expected_index` value that was present when `start_rx` was sampled.
- R8: The CRC7 uses the generator x^7+x^3+1 and starts from zero. It runs over bits 47 to 8, most significant first. `crc_err`=1 when the result differs from bits 7:1, where bit 7 is the most significant CRC bit.
- R9: After the edge that samples bit 0, `done`=1, `raw` equals the full 48-bit frame, `rca` equals bits 39:24 and `status` equals bits 23:8. These outputs hold until the next `start_rx`.
- R10: A `start_rx` sampled at an edge clears `done` and all five flags after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_rx | input | 1 | Pulse in the cycle of the host command's end bit |
| host_oe | input | 1 | High while the host drives the command line |
| cmd_in | input | 1 | Sampled command line |
| expected_index | input | 6 | Command index the reply must echo |
| done | output | 1 | Reception finished; results valid |
| rca | output | 16 | Relative card address, frame bits 39:24 |
| status | output | 16 | Card status, frame bits 23:8 |
| raw | output | 48 | Whole received frame |
| crc_err | output | 1 | CRC7 mismatch |
| frame_err | output | 1 | Bad transmission bit or missing end bit |
| index_err | output | 1 | Echoed index differs from the expected one |
| timeout | output | 1 | No start bit within the hunt window |
| early_err | output | 1 | Low bit during the turnaround |

## Verification
The bench builds the block with its default parameters: a 48-bit frame, a 2-cycle turnaround and a 64-cycle hunt window. These values are small enough that both ends of the hunt window can be reached directly. One reply starts on the last accepted edge after 63 idle bits. In another run the window expires at edge 66, and the bench also confirms that `done` is still low one edge earlier. The vector table sends replies with each framing fault on its own and with two faults combined, and it uses a non-default matching index. Directed runs cover an early low bit in the turnaround, a low line while the host still drives the line, and the clearing of a held result by `start_rx`.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_TURN,
        S_HUNT,
        S_SHIFT,
        S_DONE
    } rx_state_t;
endpackage

// File: rtl/sd_resp_crc7.sv
module sd_resp_crc7 #(
    parameter int               CRC_W = 7,
    parameter logic [CRC_W-1:0] POLY  = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;
    assign fb = din ^ crc[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // R8: the register only moves when fed or cleared
    p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/sd_resp_shifter.sv
module sd_resp_shifter #(
    parameter  int FRAME_W = 48,
    localparam int POS_W   = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame,
    output logic [POS_W-1:0]   pos,
    output logic               last
);
    localparam logic [POS_W-1:0] POS_TOP = POS_W'(FRAME_W - 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
            pos   <= POS_TOP;
        end else if (clr) begin
            frame <= '0;
            pos   <= POS_TOP;
        end else if (shift_en) begin
            frame <= {frame[FRAME_W-2:0], din};
            if (pos != '0) pos <= pos - 1'b1;
        end
    end

    assign last = (pos == '0);

    // R9: position never leaves the frame
    p_pos_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_TOP);
endmodule

// File: rtl/sd_resp_rx.sv
module sd_resp_rx
    import sd_resp_pkg::*;
#(
    parameter int FRAME_W    = 48,
    parameter int IDX_W      = 6,
    parameter int FIELD_W    = 16,
    parameter int CRC_W      = 7,
    parameter int MIN_GAP    = 2,
    parameter int HUNT_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_rx,
    input  logic               host_oe,
    input  logic               cmd_in,
    input  logic [IDX_W-1:0]   expected_index,
    output logic               done,
    output logic [FIELD_W-1:0] rca,
    output logic [FIELD_W-1:0] status,
    output logic [FRAME_W-1:0] raw,
    output logic               crc_err,
    output logic               frame_err,
    output logic               index_err,
    output logic               timeout,
    output logic               early_err
);
    localparam int POS_W  = $clog2(FRAME_W);
    localparam int CNT_W  = $clog2(HUNT_LIMIT > MIN_GAP ? HUNT_LIMIT : MIN_GAP) + 1;
    localparam int IDX_HI = FRAME_W - 3;
    localparam int ARG_HI = IDX_HI - IDX_W;
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(MIN_GAP - 1);
    localparam logic [CNT_W-1:0] HUNT_LAST = CNT_W'(HUNT_LIMIT - 1);
    localparam logic [POS_W-1:0] CRC_STOP  = POS_W'(CRC_W + 1);

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [IDX_W-1:0]   exp_idx_q;
    logic               line_low;
    logic               ev_early, ev_tmo, ev_fin;
    logic               sh_clr, sh_en, crc_clr, crc_en;
    logic [FRAME_W-1:0] frame, nf;
    logic [POS_W-1:0]   pos;
    logic               last;
    logic [CRC_W-1:0]   crc_val;

    assign line_low = !cmd_in && !host_oe;

    sd_resp_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
        .din(cmd_in), .frame(frame), .pos(pos), .last(last)
    );

    sd_resp_crc7 #(.CRC_W(CRC_W), .POLY(CRC_W'(9))) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(cmd_in), .crc(crc_val)
    );

    // next state and datapath strobes
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        ev_early = 1'b0;
        ev_tmo   = 1'b0;
        ev_fin   = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        if (start_rx) begin
            state_d = S_TURN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_DONE: ;
                S_TURN: begin
                    if (line_low) begin
                        ev_early = 1'b1;
                        state_d  = S_DONE;
                    end else if (cnt_q == GAP_LAST) begin
                        state_d = S_HUNT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_HUNT: begin
                    if (line_low) begin
                        state_d = S_SHIFT;
                        sh_clr  = 1'b1;
                        crc_clr = 1'b1;
                    end else if (cnt_q == HUNT_LAST) begin
                        ev_tmo  = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                S_SHIFT: begin
                    sh_en  = 1'b1;
                    crc_en = (pos >= CRC_STOP);
                    if (last) begin
                        ev_fin  = 1'b1;
                        state_d = S_DONE;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            exp_idx_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start_rx) exp_idx_q <= expected_index;
        end
    end

    assign nf = {frame[FRAME_W-2:0], cmd_in};

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_err   <= 1'b0;
            frame_err <= 1'b0;
            index_err <= 1'b0;
            timeout   <= 1'b0;
            early_err <= 1'b0;
        end else if (start_rx) begin
            crc_err   <= 1'b0;
            frame_err <= 1'b0;
            index_err <= 1'b0;
            timeout   <= 1'b0;
            early_err <= 1'b0;
        end else begin
            if (ev_early) early_err <= 1'b1;
            if (ev_tmo)   timeout   <= 1'b1;
            if (ev_fin) begin
                frame_err <= nf[FRAME_W-2] | ~nf[0];
                index_err <= (nf[IDX_HI -: IDX_W] != exp_idx_q);
                crc_err   <= (crc_val != nf[CRC_W:1]);
            end
        end
    end

    assign done   = (state_q == S_DONE);
    assign raw    = frame;
    assign rca    = frame[ARG_HI -: FIELD_W];
    assign status = frame[ARG_HI-FIELD_W -: FIELD_W];

    // R5: an expiry is reported alone
    p_timeout_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> !(crc_err || frame_err || index_err || early_err));
    // R2: the early flag can only come out of the turnaround
    p_early_from_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_err) |-> $past(state_q) == S_TURN);
    // R10: a new command clears the held result
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_rx |=> (!done && !crc_err && !frame_err && !index_err && !timeout && !early_err));
    // R9: a normal finish comes out of the shift state
    p_fin_from_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !timeout && !early_err) |-> $past(state_q) == S_SHIFT);
endmodule

// File: tb/sd_resp_rx_tb.sv
module sd_resp_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_rx = 1'b0;
    logic        host_oe = 1'b0;
    logic        cmd_in = 1'b1;
    logic [5:0]  expected_index = 6'd3;
    logic        done, crc_err, frame_err, index_err, timeout, early_err;
    logic [15:0] rca, status;
    logic [47:0] raw;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sd_resp_rx u_dut (
        .clk(clk), .rst_n(rst_n), .start_rx(start_rx), .host_oe(host_oe),
        .cmd_in(cmd_in), .expected_index(expected_index), .done(done),
        .rca(rca), .status(status), .raw(raw), .crc_err(crc_err),
        .frame_err(frame_err), .index_err(index_err), .timeout(timeout),
        .early_err(early_err)
    );

    typedef struct packed {
        logic [5:0]  idle;
        logic [5:0]  idx;
        logic [5:0]  exp_idx;
        logic [15:0] rca;
        logic [15:0] stat;
        logic        bad_t;
        logic        bad_e;
        logic        bad_c;
        logic        e_frame;
        logic        e_index;
        logic        e_crc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  6'd3,  6'd3,  16'h1234, 16'h0900, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd5,  6'd3,  6'd3,  16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        '{6'd63, 6'd3,  6'd3,  16'h0001, 16'h8001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd1,  6'd3,  6'd3,  16'hA5A5, 16'h5A5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{6'd2,  6'd3,  6'd3,  16'h0F0F, 16'h1200, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{6'd0,  6'd2,  6'd3,  16'hBEEF, 16'h0520, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd10, 6'h29, 6'h29, 16'h7777, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{6'd3,  6'd3,  6'd3,  16'h4321, 16'hC000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 50000", cyc);
            report();
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // the generator x^7+x^3+1 over bits 47..8, zero start
    function automatic logic [6:0] crc7(input logic [47:0] f);
        logic [6:0] c = '0;
        for (int i = 47; i >= 8; i--) begin
            logic fb = f[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] make_frame(input logic [5:0] idx, input logic [15:0] r,
        input logic [15:0] s, input logic bad_t, input logic bad_e, input logic bad_c);
        logic [47:0] f = {1'b0, bad_t, idx, r, s, 7'h00, ~bad_e};
        f[7:1] = crc7(f) ^ (bad_c ? 7'h01 : 7'h00);
        return f;
    endfunction

    task automatic put(input logic v);
        cmd_in = v;
        @(negedge clk);
    endtask

    // ends at the negedge after edge 0, with the value for edge 1 pending
    task automatic begin_cmd(input logic [5:0] idx);
        @(negedge clk);
        expected_index = idx;
        start_rx = 1'b1;
        host_oe  = 1'b1;
        cmd_in   = 1'b1;
        @(negedge clk);
        start_rx = 1'b0;
        host_oe  = 1'b0;
    endtask

    task automatic send_frame(input logic [47:0] f);
        for (int i = 47; i >= 0; i--) put(f[i]);
    endtask

    task automatic chk_flags(input string req, input logic c, input logic f,
        input logic i, input logic t, input logic e);
        chk({req, " crc_err"},   {47'b0, crc_err},   {47'b0, c});
        chk({req, " frame_err"}, {47'b0, frame_err}, {47'b0, f});
        chk({req, " index_err"}, {47'b0, index_err}, {47'b0, i});
        chk({req, " timeout"},   {47'b0, timeout},   {47'b0, t});
        chk({req, " early_err"}, {47'b0, early_err}, {47'b0, e});
    endtask

    initial begin
        logic [47:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", {47'b0, done}, 48'd0);
        chk_flags("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // table: R3 idle bits, R6 framing, R7 index, R8 CRC, R9 fields
        for (int k = 0; k < NV; k++) begin
            f = make_frame(VECS[k].idx, VECS[k].rca, VECS[k].stat,
                           VECS[k].bad_t, VECS[k].bad_e, VECS[k].bad_c);
            begin_cmd(VECS[k].exp_idx);
            put(1'b1);
            put(1'b1);
            for (int j = 0; j < int'(VECS[k].idle); j++) put(1'b1);
            send_frame(f);
            chk("R3 R9 done", {47'b0, done}, 48'd1);
            chk("R9 raw", raw, f);
            chk("R9 rca", {32'b0, rca}, {32'b0, VECS[k].rca});
            chk("R9 status", {32'b0, status}, {32'b0, VECS[k].stat});
            chk_flags("R6 R7 R8", VECS[k].e_crc, VECS[k].e_frame, VECS[k].e_index,
                      1'b0, 1'b0);
            @(negedge clk);
            chk("R9 hold", {32'b0, rca}, {32'b0, VECS[k].rca});
        end

        // R5 hunt window expires at edge 66
        begin_cmd(6'd3);
        repeat (65) put(1'b1);
        chk("R5 not yet", {47'b0, done}, 48'd0);
        put(1'b1);
        chk("R5 done", {47'b0, done}, 48'd1);
        chk_flags("R5", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R10 start clears the held result
        @(negedge clk);
        start_rx = 1'b1;
        @(negedge clk);
        start_rx = 1'b0;
        chk("R10 done", {47'b0, done}, 48'd0);
        chk_flags("R10", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2 low bit during the turnaround
        begin_cmd(6'd3);
        put(1'b1);
        put(1'b0);
        chk("R2 done", {47'b0, done}, 48'd1);
        chk_flags("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

        // R4 host still driving: low line ignored in turnaround and hunt
        f = make_frame(6'd3, 16'h2468, 16'h1357, 1'b0, 1'b0, 1'b0);
        begin_cmd(6'd3);
        host_oe = 1'b1;
        put(1'b0);
        put(1'b0);
        put(1'b0);
        put(1'b0);
        chk("R4 no start", {47'b0, done}, 48'd0);
        chk("R4 no early", {47'b0, early_err}, 48'd0);
        host_oe = 1'b0;
        send_frame(f);
        chk("R4 done", {47'b0, done}, 48'd1);
        chk("R4 rca", {32'b0, rca}, 48'h2468);
        chk_flags("R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        report();
    end
endmodule